// File: doc/BRIEF.md
# Programmable Symmetric Function Array

This block evaluates several totally symmetric Boolean functions of an N-bit input word at once. A symmetric function depends only on how many input bits are 1. Each output has its own programmable index set, so the output is 1 exactly when the ones-count of the input belongs to that set. One output might detect exactly two ones, and another might detect an odd count, a majority or a threshold.

The datapath has two regular planes. The first is a triangle of identical two-input cells. Each cell passes on the AND (minimum) and the OR (maximum) of its inputs. The triangle sorts the input bits, which yields every threshold signal T_k, meaning "at least k inputs are 1", for k = 1..N. The second plane has one XOR column per output. Each column forms the exact-count terms S_k = T_k xor T_(k+1), taking T_0 = 1 and T_(N+1) = 0, and XORs together the terms that its mask enables.

Masks are written through a simple write-enable and address port. The results are registered on the rising clock edge. N must be at least 2.

Top module: `symfn_array`

## Requirements
- R1: While rst_ni is low, every fn_o bit is 0 and every mask is cleared to all zeros. After reset, with no mask written, every output stays 0 for every input.
- R2: One clock after data_i is sampled, fn_o[m] equals bit c of the mask of output m, where c is the number of 1 bits in the sampled data_i. Mask bit k, in the range 0..N, enables ones-count k.
- R3: A mask with only bit k set makes the output 1 exactly when k inputs are 1, for each k in 0..N.
- R4: An all-zero mask gives a constant 0 output, and an all-ones mask gives a constant 1 output, whatever the input.
- R5: With cfg_we_i high at a rising edge, cfg_mask_i is loaded as the mask of output cfg_addr_i. The input sampled at the very next edge is evaluated with the new mask.
- R6: A write whose address is M or above changes no mask. All outputs keep following their previous masks.
- R7: A write to one output's mask leaves every other output's mask and results unchanged.
- R8: A mask with bits k..N set makes the output equal the threshold function "at least k inputs are 1".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | N | Input bits whose ones-count is evaluated |
| cfg_we_i | input | 1 | Mask write enable |
| cfg_addr_i | input | AW | Index of the output whose mask is written |
| cfg_mask_i | input | N+1 | Mask value; bit k enables ones-count k |
| fn_o | output | M | Registered symmetric function results |

## Verification
If a cell in the triangle is miswired, some threshold signal breaks for certain input patterns. That error shows in fn_o one clock after the offending vector, but only on outputs whose mask straddles the broken threshold. For this reason, every single-index mask and every threshold mask is swept over all 2^N inputs. If a mask register holds the wrong value, or is written by a write meant for another address, the error appears on the first vector after the write whose ones-count hits the corrupted bit. Each write is therefore followed by a full input sweep of all outputs.

// File: rtl/symfn_pkg.sv
package symfn_pkg;
  // start index of the carry chain belonging to triangle pass p
  function automatic int carry_off(input int n, input int p);
    return p * n - (p * (p - 1)) / 2;
  endfunction
endpackage

// File: rtl/symfn_minmax_cell.sv
module symfn_minmax_cell (
  input  logic a_i,
  input  logic b_i,
  output logic lo_o,
  output logic hi_o
);
  assign lo_o = a_i & b_i;
  assign hi_o = a_i | b_i;
endmodule

// File: rtl/symfn_minmax_tri.sv
module symfn_minmax_tri #(
  parameter int N = 4
) (
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] thr_o   // thr_o[k-1] = at least k ones
);
  localparam int CW = symfn_pkg::carry_off(N, N - 1);

  logic [N-1:0][N-1:0] lane;
  logic [CW-1:0]       carry;

  assign lane[0] = bits_i;

  // pass p bubbles the largest remaining bit up to lane position N-1-p
  for (genvar p = 0; p < N - 1; p++) begin : g_pass
    localparam int OFF = symfn_pkg::carry_off(N, p);
    localparam int TOP = N - 1 - p;
    assign carry[OFF] = lane[p][0];
    for (genvar j = 0; j < TOP; j++) begin : g_cell
      symfn_minmax_cell cell_i (
        .a_i (carry[OFF+j]),
        .b_i (lane[p][j+1]),
        .lo_o(lane[p+1][j]),
        .hi_o(carry[OFF+j+1])
      );
    end
    assign lane[p+1][TOP] = carry[OFF+TOP];
    for (genvar j = TOP + 1; j < N; j++) begin : g_pass_thru
      assign lane[p+1][j] = lane[p][j];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_thr
    assign thr_o[i] = lane[N-1][N-1-i];
  end
endmodule

// File: rtl/symfn_xor_col.sv
module symfn_xor_col #(
  parameter int N = 4
) (
  input  logic [N-1:0] thr_i,
  input  logic [N:0]   mask_i,
  output logic         fn_o
);
  logic [N+1:0] thr_ext;
  logic [N+1:0] acc;

  assign thr_ext[0]   = 1'b1;
  assign thr_ext[N+1] = 1'b0;
  assign thr_ext[N:1] = thr_i;
  assign acc[0]       = 1'b0;

  for (genvar k = 0; k <= N; k++) begin : g_term
    logic thr_cp;   // copy of T_k+1 via XOR with constant 0
    logic exact;
    assign thr_cp   = thr_ext[k+1] ^ 1'b0;
    assign exact    = thr_ext[k] ^ thr_cp;
    assign acc[k+1] = acc[k] ^ (mask_i[k] & exact);
  end

  assign fn_o = acc[N+1];
endmodule

// File: rtl/symfn_mask_bank.sv
module symfn_mask_bank #(
  parameter int N  = 4,
  parameter int M  = 3,
  parameter int AW = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [N:0]          wdata_i,
  output logic [M-1:0][N:0]   masks_o
);
  for (genvar m = 0; m < M; m++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              masks_o[m] <= '0;
      else if (we_i && addr_i == AW'(m))        masks_o[m] <= wdata_i;
    end
  end
endmodule

// File: rtl/symfn_array.sv
module symfn_array #(
  parameter int N  = 4,
  parameter int M  = 3,
  parameter int AW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  data_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [N:0]    cfg_mask_i,
  output logic [M-1:0]  fn_o
);
  logic [N-1:0]      thr;
  logic [M-1:0][N:0] mask_q;
  logic [M-1:0]      fn_d;
  logic [M-1:0]      fn_q;

  symfn_minmax_tri #(.N(N)) tri_i (
    .bits_i(data_i),
    .thr_o (thr)
  );

  symfn_mask_bank #(.N(N), .M(M), .AW(AW)) bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_mask_i),
    .masks_o(mask_q)
  );

  for (genvar m = 0; m < M; m++) begin : g_col
    symfn_xor_col #(.N(N)) col_i (
      .thr_i (thr),
      .mask_i(mask_q[m]),
      .fn_o  (fn_d[m])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fn_q <= '0;
    else         fn_q <= fn_d;
  end

  assign fn_o = fn_q;
endmodule

// File: rtl/symfn_array_chk.sv
module symfn_array_chk #(
  parameter int N  = 4,
  parameter int M  = 3,
  parameter int AW = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0]        data_i,
  input logic                cfg_we_i,
  input logic [AW-1:0]       cfg_addr_i,
  input logic [N:0]          cfg_mask_i,
  input logic [M-1:0][N:0]   masks_i,
  input logic [M-1:0]        fn_o
);
  for (genvar m = 0; m < M; m++) begin : g_out
    p_count_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn_o[m] == $past(masks_i[m][$countones(data_i)]));

    p_const_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(masks_i[m] == '0) |-> !fn_o[m]);

    p_const_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(masks_i[m] == '1) |-> fn_o[m]);

    p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_we_i && cfg_addr_i == AW'(m)) |-> masks_i[m] == $past(cfg_mask_i));

    // covers R6 and R7: only a write addressed to m may touch mask m
    p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cfg_we_i && cfg_addr_i == AW'(m)) |-> $stable(masks_i[m]));
  end
endmodule

bind symfn_array symfn_array_chk #(.N(N), .M(M), .AW(AW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .cfg_we_i  (cfg_we_i),
  .cfg_addr_i(cfg_addr_i),
  .cfg_mask_i(cfg_mask_i),
  .masks_i   (mask_q),
  .fn_o      (fn_o)
);

// File: tb/symfn_array_tb_top.sv
module symfn_array_tb_top;
  localparam int N     = 4;
  localparam int M     = 3;
  localparam int AW    = 2;
  localparam int CLK_P = 10;

  typedef struct {
    logic [M-1:0] exp;
    string        tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  data = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [N:0]    cfg_mask = '0;
  logic [M-1:0]  fn;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  logic [N:0] mdl [M];

  always #(CLK_P/2) clk = ~clk;

  symfn_array #(.N(N), .M(M), .AW(AW)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .data_i    (data),
    .cfg_we_i  (cfg_we),
    .cfg_addr_i(cfg_addr),
    .cfg_mask_i(cfg_mask),
    .fn_o      (fn)
  );

  function automatic logic [M-1:0] model(input logic [N-1:0] d);
    logic [M-1:0] r;
    for (int m = 0; m < M; m++) r[m] = mdl[m][$countones(d)];
    return r;
  endfunction

  task automatic check(input logic [M-1:0] act, input logic [M-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fn_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = 1'b0;
    data   = d;
    it.exp = model(d);
    it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
  endtask

  task automatic cfg(input int addr, input logic [N:0] mask);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = AW'(addr);
    cfg_mask = mask;
    @(posedge clk);
    if (addr < M) mdl[addr] = mask;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N); v++) apply(N'(v), tag);
  endtask

  // monitor: one result per applied vector, seen at the following negedge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(fn, it.exp, it.tag);
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < M; m++) mdl[m] = '0;
    data = '1;
    repeat (3) @(negedge clk);
    check(fn, '0, "R1 reset");
    rst_n = 1'b1;
    sweep("R1 post-reset");

    // R3: single count per mask bit
    for (int k = 0; k <= N; k++) begin
      cfg(0, (N+1)'(1) << k);
      sweep("R3 exact count");
    end

    // R8 thresholds on output 1; R7 output 0 untouched
    for (int k = 1; k <= N; k++) begin
      cfg(1, ~(((N+1)'(1) << k) - 1'b1));
      sweep("R8 threshold");
    end

    // R4 constants
    cfg(2, '1);
    sweep("R4 all ones");
    cfg(2, '0);
    sweep("R4 all zero");

    // R5 new mask applies to the next sampled vector
    cfg(0, (N+1)'(1) << 2);
    apply(N'(3), "R5 load");
    cfg(0, (N+1)'(1) << 1);
    apply(N'(3), "R5 reload");
    cfg(2, (N+1)'(1) << 2);
    sweep("R7 neighbours held");

    // R6 out-of-range address ignored
    cfg(M, '1);
    sweep("R6 bad address");

    // R2 random index sets
    for (int r = 0; r < 20; r++) begin
      for (int m = 0; m < M; m++) cfg(m, (N+1)'($urandom));
      sweep("R2 random mask");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule